// File: doc/BRIEF.md
# Packed Posit Max and ReLU Unit

This block treats a 32-bit register as a set of packed posit lanes and performs the operations that only need the ordering of posit values: maximum, minimum, less-than and equal flags, and ReLU. Posit bit patterns order the same way as signed two's-complement integers of the same width. Every comparison is therefore a plain signed integer compare on each lane. No posit decoding and no floating-point comparator are involved. A width field picks four 8-bit lanes, two 16-bit lanes or one 32-bit lane. Lanes never exchange carries or comparison results.

A second path handles streams. It tracks a running per-lane maximum and the position where that maximum first appeared across a sequence of words. This serves max-pooling windows and the final argmax of an inference. A start flag opens a sequence and a last flag closes it. One cycle after the closing word, a single-cycle done pulse presents the result.

Top module: `lanecmp_unit`

## Requirements
- R1: While reset is held and after its release, res_valid, st_done, res_max, res_min, res_relu, res_lt, res_eq, res_exc, st_max and st_idx are all zero.
- R2: Width code 0 selects four 8-bit lanes, with lane i in bits [8i+7:8i]. Code 1 selects two 16-bit lanes, with lane i in bits [16i+15:16i]. Codes 2 and 3 both select one 32-bit lane.
- R3: A request with op_valid high produces its results on the cycle after it is accepted. res_valid is high for exactly that one cycle per request.
- R4: In each lane, res_max and res_min hold the larger and the smaller of the lanes of op_a and op_b under signed two's-complement order. The pattern with only the lane's top bit set is the smallest value.
- R5: Flag bit i of res_lt is set when lane i of op_a is less than lane i of op_b. Flag bit i of res_eq is set when the two lanes are equal. Flag bits above the last active lane are zero.
- R6: In each lane, res_relu holds op_a's lane when that lane's top bit is clear, and zero otherwise.
- R7: The result of one lane depends only on that lane's bits of op_a and op_b, so the same operands give different results in different width modes.
- R8: res_exc is set when any active lane of op_a holds the pattern with only its top bit set.
- R9: An accepted word with st_start high loads itself as the running maximum of every lane, with index 0. The width code st_width is sampled at that moment and used for the whole sequence.
- R10: Each later accepted word counts as the next position. A lane's maximum and index are replaced only when the new lane value is strictly greater. Ties keep the earlier index, and cycles with st_valid low do not count.
- R11: st_done pulses for one cycle, on the cycle after the word carrying st_last is accepted. At that point st_max holds the lane maxima and st_idx holds lane i's index in bits [8i+7:8i]. A word with both st_start and st_last high forms a sequence of length one.
- R12: When no sequence is open, a word with st_valid high and st_start low is ignored. It raises no done pulse and leaves st_max and st_idx unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Pairwise request strobe |
| op_width | input | 2 | Lane width code for the request |
| op_a | input | 32 | First packed operand, also the ReLU source |
| op_b | input | 32 | Second packed operand |
| res_valid | output | 1 | Results valid, one cycle after the request |
| res_max | output | 32 | Lane-wise maximum |
| res_min | output | 32 | Lane-wise minimum |
| res_relu | output | 32 | Lane-wise ReLU of op_a |
| res_lt | output | 4 | Per-lane a < b flags |
| res_eq | output | 4 | Per-lane a == b flags |
| res_exc | output | 1 | Some lane of op_a holds the exception pattern |
| st_valid | input | 1 | Stream word strobe |
| st_start | input | 1 | Word opens a new sequence |
| st_last | input | 1 | Word closes the sequence |
| st_width | input | 2 | Lane width code, sampled with st_start |
| st_data | input | 32 | Stream word |
| st_done | output | 1 | One-cycle pulse with the final result |
| st_max | output | 32 | Running or final lane maxima |
| st_idx | output | 32 | Per-lane index of the maximum, 8 bits per lane |

## Verification
The pairwise path is tested with operands whose signs differ between lanes. This shows whether each lane uses signed order rather than unsigned order. The same operands are then sent in every width code, so any carry or comparison that leaks across a lane boundary changes the expected word. Further patterns include equal lanes, the exception pattern against the largest positive value, and all-negative inputs for ReLU. The stream path is tested with three kinds of sequence: repeated maxima that separate a strict compare from a non-strict one, packed byte lanes whose winners sit at different positions, and a one-word sequence. Stray words outside a sequence, and bubbles inside one, confirm that only counted words move the index.

// File: rtl/lanecmp_pkg.sv
package lanecmp_pkg;

  // Fold width codes beyond the widest mode onto the widest mode.
  function automatic int clamp_mode(input int code, input int nmode);
    return (code >= nmode) ? nmode - 1 : code;
  endfunction

  // Number of active lanes for a folded mode.
  function automatic int lanes_in_mode(input int code, input int nmode, input int nbase);
    return nbase >> clamp_mode(code, nmode);
  endfunction

endpackage

// File: rtl/lanecmp_packed.sv
// Lane-wise signed less-than of x against y for every width mode, muxed by mode.
// take_y is expanded to base-lane granularity so callers can pick bytes directly.
module lanecmp_packed #(
  parameter int DATA_W = 32,
  parameter int BASE_W = 8,
  parameter int NMODE  = 3,
  parameter int MODE_W = 2
) (
  input  logic [MODE_W-1:0]        mode,
  input  logic [DATA_W-1:0]        x,
  input  logic [DATA_W-1:0]        y,
  output logic [DATA_W/BASE_W-1:0] lt,
  output logic [DATA_W/BASE_W-1:0] take_y
);
  import lanecmp_pkg::*;

  localparam int NBASE = DATA_W / BASE_W;

  logic [NMODE*NBASE-1:0] lt_all;
  logic [NMODE*NBASE-1:0] take_all;
  int msel;

  for (genvar m = 0; m < NMODE; m++) begin : g_mode
    localparam int LW   = BASE_W << m;
    localparam int NL   = DATA_W / LW;
    localparam int SPAN = LW / BASE_W;
    logic [NL-1:0] lt_l;

    for (genvar l = 0; l < NL; l++) begin : g_lane
      assign lt_l[l] = $signed(x[l*LW +: LW]) < $signed(y[l*LW +: LW]);
    end

    for (genvar k = 0; k < NBASE; k++) begin : g_base
      assign take_all[m*NBASE + k] = lt_l[k/SPAN];
      if (k < NL) begin : g_used
        assign lt_all[m*NBASE + k] = lt_l[k];
      end else begin : g_unused
        assign lt_all[m*NBASE + k] = 1'b0;
      end
    end
  end

  always_comb begin
    msel   = clamp_mode(int'(mode), NMODE);
    lt     = lt_all[msel*NBASE +: NBASE];
    take_y = take_all[msel*NBASE +: NBASE];
  end

endmodule

// File: rtl/lanecmp_unary.sv
// ReLU and exception-pattern detection on one packed operand.
module lanecmp_unary #(
  parameter int DATA_W = 32,
  parameter int BASE_W = 8,
  parameter int NMODE  = 3,
  parameter int MODE_W = 2
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [DATA_W-1:0] a,
  output logic [DATA_W-1:0] relu,
  output logic              exc
);
  import lanecmp_pkg::*;

  localparam int NBASE = DATA_W / BASE_W;

  logic [NMODE*NBASE-1:0] neg_all;
  logic [NMODE-1:0]       exc_all;
  logic [NBASE-1:0]       neg;
  int msel;

  for (genvar m = 0; m < NMODE; m++) begin : g_mode
    localparam int LW   = BASE_W << m;
    localparam int NL   = DATA_W / LW;
    localparam int SPAN = LW / BASE_W;
    logic [NL-1:0] neg_l;
    logic [NL-1:0] exc_l;

    for (genvar l = 0; l < NL; l++) begin : g_lane
      assign neg_l[l] = a[l*LW + LW - 1];
      assign exc_l[l] = (a[l*LW +: LW] == {1'b1, {(LW-1){1'b0}}});
    end

    for (genvar k = 0; k < NBASE; k++) begin : g_base
      assign neg_all[m*NBASE + k] = neg_l[k/SPAN];
    end

    assign exc_all[m] = |exc_l;
  end

  always_comb begin
    msel = clamp_mode(int'(mode), NMODE);
    neg  = neg_all[msel*NBASE +: NBASE];
    exc  = exc_all[msel];
    for (int k = 0; k < NBASE; k++) begin
      relu[k*BASE_W +: BASE_W] = neg[k] ? '0 : a[k*BASE_W +: BASE_W];
    end
  end

endmodule

// File: rtl/lanecmp_stream.sv
// Running per-lane maximum with first-occurrence index over a framed sequence.
module lanecmp_stream #(
  parameter int DATA_W = 32,
  parameter int BASE_W = 8,
  parameter int NMODE  = 3,
  parameter int MODE_W = 2,
  parameter int IDX_W  = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              st_valid,
  input  logic                              st_start,
  input  logic                              st_last,
  input  logic [MODE_W-1:0]                 st_width,
  input  logic [DATA_W-1:0]                 st_data,
  output logic                              st_done,
  output logic [DATA_W-1:0]                 st_max,
  output logic [(DATA_W/BASE_W)*IDX_W-1:0]  st_idx
);
  localparam int NBASE = DATA_W / BASE_W;

  logic              busy_q;
  logic [MODE_W-1:0] mode_q;
  logic [IDX_W-1:0]  pos_q;
  logic [NBASE-1:0]  gt_lane;
  logic [NBASE-1:0]  gt_base;
  logic [DATA_W-1:0] max_next;

  lanecmp_packed #(
    .DATA_W(DATA_W), .BASE_W(BASE_W), .NMODE(NMODE), .MODE_W(MODE_W)
  ) u_cmp (
    .mode  (mode_q),
    .x     (st_max),
    .y     (st_data),
    .lt    (gt_lane),
    .take_y(gt_base)
  );

  always_comb begin
    for (int k = 0; k < NBASE; k++) begin
      max_next[k*BASE_W +: BASE_W] = gt_base[k] ? st_data[k*BASE_W +: BASE_W]
                                                : st_max[k*BASE_W +: BASE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      mode_q  <= '0;
      pos_q   <= '0;
      st_done <= 1'b0;
      st_max  <= '0;
      st_idx  <= '0;
    end else begin
      st_done <= 1'b0;
      if (st_valid) begin
        if (st_start) begin
          busy_q  <= !st_last;
          mode_q  <= st_width;
          st_max  <= st_data;
          st_idx  <= '0;
          pos_q   <= IDX_W'(1);
          st_done <= st_last;
        end else if (busy_q) begin
          st_max <= max_next;
          for (int l = 0; l < NBASE; l++) begin
            if (gt_lane[l]) begin
              st_idx[l*IDX_W +: IDX_W] <= pos_q;
            end
          end
          pos_q <= pos_q + IDX_W'(1);
          if (st_last) begin
            busy_q  <= 1'b0;
            st_done <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/lanecmp_unit.sv
// Packed posit max / min / compare / ReLU with a streaming argmax path.
module lanecmp_unit #(
  parameter int DATA_W = 32,
  parameter int BASE_W = 8,
  parameter int IDX_W  = 8,
  localparam int NBASE  = DATA_W / BASE_W,
  localparam int NMODE  = $clog2(NBASE) + 1,
  localparam int MODE_W = (NMODE > 1) ? $clog2(NMODE) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    op_valid,
  input  logic [MODE_W-1:0]       op_width,
  input  logic [DATA_W-1:0]       op_a,
  input  logic [DATA_W-1:0]       op_b,
  output logic                    res_valid,
  output logic [DATA_W-1:0]       res_max,
  output logic [DATA_W-1:0]       res_min,
  output logic [DATA_W-1:0]       res_relu,
  output logic [NBASE-1:0]        res_lt,
  output logic [NBASE-1:0]        res_eq,
  output logic                    res_exc,
  input  logic                    st_valid,
  input  logic                    st_start,
  input  logic                    st_last,
  input  logic [MODE_W-1:0]       st_width,
  input  logic [DATA_W-1:0]       st_data,
  output logic                    st_done,
  output logic [DATA_W-1:0]       st_max,
  output logic [NBASE*IDX_W-1:0]  st_idx
);
  import lanecmp_pkg::*;

  logic [NBASE-1:0]  lt_ab, tk_ab, lt_ba, tk_ba, lane_on, eq_c;
  logic [DATA_W-1:0] max_c, min_c, relu_c;
  logic              exc_c;
  int                nlanes;

  lanecmp_packed #(
    .DATA_W(DATA_W), .BASE_W(BASE_W), .NMODE(NMODE), .MODE_W(MODE_W)
  ) u_ab (
    .mode(op_width), .x(op_a), .y(op_b), .lt(lt_ab), .take_y(tk_ab)
  );

  lanecmp_packed #(
    .DATA_W(DATA_W), .BASE_W(BASE_W), .NMODE(NMODE), .MODE_W(MODE_W)
  ) u_ba (
    .mode(op_width), .x(op_b), .y(op_a), .lt(lt_ba), .take_y(tk_ba)
  );

  lanecmp_unary #(
    .DATA_W(DATA_W), .BASE_W(BASE_W), .NMODE(NMODE), .MODE_W(MODE_W)
  ) u_una (
    .mode(op_width), .a(op_a), .relu(relu_c), .exc(exc_c)
  );

  always_comb begin
    nlanes = lanes_in_mode(int'(op_width), NMODE, NBASE);
    for (int k = 0; k < NBASE; k++) begin
      lane_on[k] = (k < nlanes);
      max_c[k*BASE_W +: BASE_W] = tk_ab[k] ? op_b[k*BASE_W +: BASE_W] : op_a[k*BASE_W +: BASE_W];
      min_c[k*BASE_W +: BASE_W] = tk_ba[k] ? op_b[k*BASE_W +: BASE_W] : op_a[k*BASE_W +: BASE_W];
    end
    eq_c = ~lt_ab & ~lt_ba & lane_on;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_max   <= '0;
      res_min   <= '0;
      res_relu  <= '0;
      res_lt    <= '0;
      res_eq    <= '0;
      res_exc   <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_max  <= max_c;
        res_min  <= min_c;
        res_relu <= relu_c;
        res_lt   <= lt_ab;
        res_eq   <= eq_c;
        res_exc  <= exc_c;
      end
    end
  end

  lanecmp_stream #(
    .DATA_W(DATA_W), .BASE_W(BASE_W), .NMODE(NMODE), .MODE_W(MODE_W), .IDX_W(IDX_W)
  ) u_stream (
    .clk     (clk),
    .rst     (rst),
    .st_valid(st_valid),
    .st_start(st_start),
    .st_last (st_last),
    .st_width(st_width),
    .st_data (st_data),
    .st_done (st_done),
    .st_max  (st_max),
    .st_idx  (st_idx)
  );

endmodule

// File: rtl/lanecmp_chk.sv
module lanecmp_chk #(
  parameter int DATA_W = 32,
  parameter int NBASE  = 4,
  parameter int NMODE  = 3,
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [MODE_W-1:0] op_width,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_max,
  input logic [DATA_W-1:0] res_min,
  input logic [DATA_W-1:0] res_relu,
  input logic [NBASE-1:0]  res_lt,
  input logic [NBASE-1:0]  res_eq,
  input logic              st_valid,
  input logic              st_last,
  input logic              st_done
);

  AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid); // R3

  AST_LT_EQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ((res_lt & res_eq) == '0)); // R5

  AST_WORD_MAX_PICKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    (op_valid && int'(op_width) == NMODE - 1) |=>
      (res_max == $past(op_a) || res_max == $past(op_b))); // R4

  AST_WORD_MAX_ABOVE_MIN: assert property (@(posedge clk) disable iff (rst)
    (op_valid && int'(op_width) == NMODE - 1) |=>
      ($signed(res_max) >= $signed(res_min))); // R4

  AST_WORD_RELU_PASS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && int'(op_width) == NMODE - 1 && !op_a[DATA_W-1]) |=>
      (res_relu == $past(op_a))); // R6

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    st_done |-> $past(st_valid && st_last)); // R11

endmodule

bind lanecmp_unit lanecmp_chk #(
  .DATA_W(DATA_W), .NBASE(NBASE), .NMODE(NMODE), .MODE_W(MODE_W)
) i_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_width(op_width),
  .op_a(op_a), .op_b(op_b), .res_valid(res_valid), .res_max(res_max),
  .res_min(res_min), .res_relu(res_relu), .res_lt(res_lt), .res_eq(res_eq),
  .st_valid(st_valid), .st_last(st_last), .st_done(st_done)
);

// File: tb/test_lanecmp_unit.sv
module test_lanecmp_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [1:0]  op_width = 2'd0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        res_valid;
  logic [31:0] res_max, res_min, res_relu;
  logic [3:0]  res_lt, res_eq;
  logic        res_exc;
  logic        st_valid = 1'b0, st_start = 1'b0, st_last = 1'b0;
  logic [1:0]  st_width = 2'd0;
  logic [31:0] st_data = '0;
  logic        st_done;
  logic [31:0] st_max, st_idx;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] seq [8];

  always #4 clk = ~clk;

  lanecmp_unit i_lanecmp_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_width(op_width),
    .op_a(op_a), .op_b(op_b), .res_valid(res_valid), .res_max(res_max),
    .res_min(res_min), .res_relu(res_relu), .res_lt(res_lt), .res_eq(res_eq),
    .res_exc(res_exc), .st_valid(st_valid), .st_start(st_start), .st_last(st_last),
    .st_width(st_width), .st_data(st_data), .st_done(st_done), .st_max(st_max),
    .st_idx(st_idx)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int lanes_for(input logic [1:0] code);
    return (code == 2'd0) ? 4 : (code == 2'd1) ? 2 : 1;
  endfunction

  // Lane value scaled to the top of a word so signed order is kept.
  function automatic logic signed [31:0] lane_key(input logic [31:0] w, input int l, input int lw);
    logic [31:0] v;
    v = (w >> (l*lw)) & ((lw == 32) ? 32'hFFFF_FFFF : ((32'd1 << lw) - 1));
    return $signed(v << (32 - lw));
  endfunction

  function automatic logic [31:0] lane_raw(input logic [31:0] w, input int l, input int lw);
    return (w >> (l*lw)) & ((lw == 32) ? 32'hFFFF_FFFF : ((32'd1 << lw) - 1));
  endfunction

  task automatic ref_op(input logic [1:0] code, input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] mx, output logic [31:0] mn, output logic [31:0] rl,
                        output logic [3:0] lt, output logic [3:0] eq, output logic ex);
    int nl, lw;
    nl = lanes_for(code);
    lw = 32 / nl;
    mx = '0; mn = '0; rl = '0; lt = '0; eq = '0; ex = 1'b0;
    for (int l = 0; l < nl; l++) begin
      logic [31:0] av, bv;
      av = lane_raw(a, l, lw);
      bv = lane_raw(b, l, lw);
      if (lane_key(a, l, lw) < lane_key(b, l, lw)) begin
        lt[l] = 1'b1;
        mx |= bv << (l*lw);
        mn |= av << (l*lw);
      end else begin
        mx |= av << (l*lw);
        mn |= bv << (l*lw);
      end
      if (av == bv) eq[l] = 1'b1;
      if (lane_key(a, l, lw) >= 0) rl |= av << (l*lw);
      if (av == (32'd1 << (lw - 1))) ex = 1'b1;
    end
  endtask

  task automatic do_op(input logic [1:0] code, input logic [31:0] a, input logic [31:0] b,
                       input string tag);
    logic [31:0] mx, mn, rl;
    logic [3:0]  lt, eq;
    logic        ex;
    ref_op(code, a, b, mx, mn, rl, lt, eq, ex);
    @(negedge clk);
    op_valid = 1'b1; op_width = code; op_a = a; op_b = b;
    @(negedge clk);
    op_valid = 1'b0;
    check({tag, " R3 valid"},        {31'd0, res_valid}, 32'd1);
    check({tag, " R2 R4 max"},       res_max, mx);
    check({tag, " R2 R4 min"},       res_min, mn);
    check({tag, " R6 relu"},         res_relu, rl);
    check({tag, " R5 lt"},           {28'd0, res_lt}, {28'd0, lt});
    check({tag, " R5 eq"},           {28'd0, res_eq}, {28'd0, eq});
    check({tag, " R8 exc"},          {31'd0, res_exc}, {31'd0, ex});
    @(negedge clk);
    check({tag, " R3 single pulse"}, {31'd0, res_valid}, 32'd0);
  endtask

  task automatic t_reset_state();
    check("R1 res_valid", {31'd0, res_valid}, 32'd0);
    check("R1 res_max",   res_max, 32'd0);
    check("R1 res_relu",  res_relu, 32'd0);
    check("R1 flags",     {24'd0, res_lt, res_eq}, 32'd0);
    check("R1 st_done",   {31'd0, st_done}, 32'd0);
    check("R1 st_max",    st_max, 32'd0);
    check("R1 st_idx",    st_idx, 32'd0);
  endtask

  task automatic t_word_ops();
    do_op(2'd2, 32'h4000_0000, 32'hC000_0000, "word sign");
    do_op(2'd2, 32'h8000_0000, 32'h7FFF_FFFF, "word exception vs top");
    do_op(2'd3, 32'h0000_1234, 32'h0000_1234, "code3 equal");
  endtask

  task automatic t_byte_ops();
    do_op(2'd0, 32'h7F80_0105, 32'h8001_0203, "byte mixed");
    do_op(2'd0, 32'hFF80_C0A0, 32'h0000_0000, "byte all negative");
    do_op(2'd0, 32'h1122_3344, 32'h1123_3340, "byte partial equal");
  endtask

  task automatic t_half_ops();
    do_op(2'd1, 32'hFFFF_0001, 32'h0000_0001, "half neg and eq");
    do_op(2'd1, 32'h8000_7FFF, 32'h7FFF_8000, "half extremes");
  endtask

  // R7: same operands through every width code must give lane-local results.
  task automatic t_lane_isolation();
    do_op(2'd0, 32'h0000_8000, 32'h0000_7FFF, "R7 iso byte");
    do_op(2'd1, 32'h0000_8000, 32'h0000_7FFF, "R7 iso half");
    do_op(2'd2, 32'h0000_8000, 32'h0000_7FFF, "R7 iso word");
  endtask

  task automatic run_stream(input logic [1:0] code, input int n, input bit bubble,
                            input string tag);
    int nl, lw;
    logic [31:0] emax, eidx;
    nl = lanes_for(code);
    lw = 32 / nl;
    emax = '0; eidx = '0;
    for (int l = 0; l < nl; l++) begin
      int bi;
      bi = 0;
      for (int i = 1; i < n; i++) begin
        if (lane_key(seq[i], l, lw) > lane_key(seq[bi], l, lw)) bi = i;
      end
      emax |= lane_raw(seq[bi], l, lw) << (l*lw);
      eidx |= 32'(bi) << (l*8);
    end
    for (int i = 0; i < n; i++) begin
      if (bubble && i == 2) begin
        @(negedge clk);
        st_valid = 1'b0;
      end
      @(negedge clk);
      st_valid = 1'b1; st_start = (i == 0); st_last = (i == n - 1);
      st_width = code; st_data = seq[i];
    end
    @(negedge clk);
    st_valid = 1'b0; st_start = 1'b0; st_last = 1'b0;
    check({tag, " R11 done"},       {31'd0, st_done}, 32'd1);
    check({tag, " R10 R11 max"},    st_max, emax);
    check({tag, " R9 R10 idx"},     st_idx, eidx);
    @(negedge clk);
    check({tag, " R11 done width"}, {31'd0, st_done}, 32'd0);
  endtask

  task automatic t_stream_word_ties();
    seq[0] = 32'd5; seq[1] = 32'd9; seq[2] = 32'hFFFF_FFFD; seq[3] = 32'd9; seq[4] = 32'd2;
    run_stream(2'd2, 5, 1'b1, "R10 ties");
  endtask

  task automatic t_stream_bytes();
    seq[0] = 32'h0102_0380; seq[1] = 32'h0502_8180;
    seq[2] = 32'h057F_0080; seq[3] = 32'h0403_FF81;
    run_stream(2'd0, 4, 1'b0, "R9 packed bytes");
  endtask

  task automatic t_stream_single();
    seq[0] = 32'h8000_1234;
    run_stream(2'd1, 1, 1'b0, "R11 single word");
  endtask

  // R12: a word without start while idle must change nothing.
  task automatic t_stream_ignored();
    logic [31:0] hold_max, hold_idx;
    hold_max = st_max;
    hold_idx = st_idx;
    @(negedge clk);
    st_valid = 1'b1; st_start = 1'b0; st_last = 1'b1; st_width = 2'd2;
    st_data = 32'h7FFF_FFFF;
    @(negedge clk);
    st_valid = 1'b0; st_last = 1'b0;
    check("R12 no done",      {31'd0, st_done}, 32'd0);
    check("R12 max kept",     st_max, hold_max);
    check("R12 idx kept",     st_idx, hold_idx);
  endtask

  initial begin
    #(8 * 50000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_stream_ignored();
    t_word_ops();
    t_byte_ops();
    t_half_ops();
    t_lane_isolation();
    t_stream_word_ties();
    t_stream_bytes();
    t_stream_single();
    t_stream_ignored();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule